// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a stream of memory requests and the command port of one DRAM device with eight banks. Each request names a bank, a row and a column and says whether it reads or writes. The sequencer keeps every row open after use. A later request to the same open row goes straight to a column command. A request to a closed bank first activates its row. A request to a bank whose open row is a different one first closes that row with a precharge and then activates the new row.

Every bank has its own open-row register and its own timers for the row-to-column delay, the minimum active time and the precharge recovery time. All of them count in command-clock cycles. A refresh timer forces a periodic refresh. When it expires, new requests are held off, any request already accepted is finished, every open bank is precharged, and a REFRESH is issued. All banks then stay blocked for a recovery time. The sequencer issues at most one command per cycle and serves requests strictly in arrival order. It pulses a hit or a miss flag with the first command of each request.

Top module: `dramSeq`

## Requirements
- R1: `cmdKind` uses the encoding 0 = idle, 1 = ACTIVATE, 2 = READ, 3 = WRITE, 4 = PRECHARGE, 5 = REFRESH. The sequencer tracks the open row of each of the eight banks (3-bit bank field) independently. ACTIVATE is issued only to a closed bank. READ and WRITE are issued only to an open bank, and only when that bank's open row equals the request's row.
- R2: A READ or WRITE to a bank comes at least `T_RCD` cycles after that bank's ACTIVATE.
- R3: A PRECHARGE to a bank comes at least `T_RAS` cycles after that bank's ACTIVATE.
- R4: An ACTIVATE to a bank comes at least `T_RP` cycles after that bank's PRECHARGE.
- R5: When no timer limits it, an accepted request to an idle closed bank issues ACTIVATE in the cycle after acceptance and its column command exactly `T_RCD` cycles later. A request to the open row that is accepted while the previous column command issues gets its own column command in the very next cycle. A request that conflicts with the open row issues PRECHARGE at the earliest allowed cycle, ACTIVATE exactly `T_RP` cycles later and its column command exactly `T_RCD` after that.
- R6: `rowHit` or `rowMiss` pulses, never both, for one cycle together with the first command of each request. Hit means that this first command is the column command. Exactly one pulse occurs per request.
- R7: REFRESH is issued only when all banks are closed. No ACTIVATE follows it within `T_RFC` cycles. Two consecutive REFRESH commands are at least `T_REFI` cycles apart and at most `T_REFI` plus a bounded service delay apart.
- R8: Column commands come out in acceptance order. Each one carries the bank, row and column of its request and is a READ or a WRITE as that request asked.
- R9: During and right after reset `cmdKind` is 0, both flags are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request is taken on this edge when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 3 | Bank of the request |
| reqRow | input | ROW_W | Row of the request |
| reqCol | input | COL_W | Column of the request |
| cmdKind | output | 3 | Command issued this cycle (encoding in R1) |
| cmdBank | output | 3 | Bank of the command |
| cmdRow | output | ROW_W | Row, meaningful with ACTIVATE |
| cmdCol | output | COL_W | Column, meaningful with READ and WRITE |
| rowHit | output | 1 | First command of a request was its column command |
| rowMiss | output | 1 | First command of a request was ACTIVATE or PRECHARGE |

## Verification
A request taken on an edge is held for one cycle. Its first command therefore shows on the command port in the cycle after acceptance, and the hit or miss flag shows in that same cycle. Each later command of the request lands exactly when its bank timer allows it: `T_RCD`, `T_RAS` or `T_RP` cycles after the command that started that timer. The bench records the cycle number at which each request is taken and reads every command half a cycle after the edge that produced it. It checks the first trace after reset against those exact cycles. It checks every later command against minimum gaps computed from its own per-bank record of the last ACTIVATE, PRECHARGE and REFRESH.

// File: rtl/dramSeqPkg.sv
package dramSeqPkg;
  localparam int BANKS  = 8;
  localparam int BANK_W = 3;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmdKind_e;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic              accept;  // load the pending request register
    logic              forReq;  // command serves the pending request
    logic              act;
    logic              col;
    logic              pre;
    logic              refr;
    logic [BANK_W-1:0] bank;
  } seqStrobe_t;
endpackage

// File: rtl/dramSeqPath.sv
module dramSeqPath
  import dramSeqPkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int T_RCD = 11,
  parameter int T_RAS = 28,
  parameter int T_RP  = 11,
  parameter int T_RFC = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              pendValid,
  output logic [BANK_W-1:0] pendBank,
  output logic              rowMatch,
  output logic [BANKS-1:0]  bankOpen,
  output logic [BANKS-1:0]  rcdDone,
  output logic [BANKS-1:0]  rasDone,
  output logic [BANKS-1:0]  rpDone,
  output logic [2:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              rowHit,
  output logic              rowMiss
);
  localparam int T_MAX1 = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int T_MAX2 = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

  logic              pendWrite;
  logic              pendFirst;
  logic [ROW_W-1:0]  pendRow;
  logic [COL_W-1:0]  pendCol;
  logic [ROW_W-1:0]  openRow [BANKS];
  logic              anyCmd;

  assign anyCmd   = stb.act | stb.col | stb.pre;
  assign rowMatch = (openRow[pendBank] == pendRow);

  // pending request register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendFirst <= 1'b0;
      pendWrite <= 1'b0;
      pendBank  <= '0;
      pendRow   <= '0;
      pendCol   <= '0;
    end else if (stb.accept) begin
      pendValid <= 1'b1;
      pendFirst <= 1'b1;
      pendWrite <= reqWrite;
      pendBank  <= reqBank;
      pendRow   <= reqRow;
      pendCol   <= reqCol;
    end else begin
      if (stb.col) pendValid <= 1'b0;
      if (stb.forReq && anyCmd) pendFirst <= 1'b0;
    end
  end

  // per-bank open row and timers
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic             isOpen;
    logic [ROW_W-1:0] rowReg;
    logic [CNT_W-1:0] rcdCnt, rasCnt, rpCnt;
    logic             sel;

    assign sel = (stb.bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        isOpen <= 1'b0;
        rowReg <= '0;
        rcdCnt <= '0;
        rasCnt <= '0;
        rpCnt  <= '0;
      end else begin
        if (stb.act && sel) begin
          isOpen <= 1'b1;
          rowReg <= pendRow;
          rcdCnt <= RCD_LD;
          rasCnt <= RAS_LD;
        end else begin
          if (rcdCnt != '0) rcdCnt <= rcdCnt - 1'b1;
          if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
        end
        if (stb.pre && sel) begin
          isOpen <= 1'b0;
          rpCnt  <= RP_LD;
        end else if (stb.refr) begin
          rpCnt  <= RFC_LD;
        end else if (rpCnt != '0) begin
          rpCnt  <= rpCnt - 1'b1;
        end
      end
    end

    assign bankOpen[g] = isOpen;
    assign openRow[g]  = rowReg;
    assign rcdDone[g]  = (rcdCnt == '0);
    assign rasDone[g]  = (rasCnt == '0);
    assign rpDone[g]   = (rpCnt == '0);
  end

  // command port register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdKind <= CMD_NOP;
      cmdBank <= '0;
      cmdRow  <= '0;
      cmdCol  <= '0;
      rowHit  <= 1'b0;
      rowMiss <= 1'b0;
    end else begin
      if (stb.act)       cmdKind <= CMD_ACT;
      else if (stb.col)  cmdKind <= pendWrite ? CMD_WR : CMD_RD;
      else if (stb.pre)  cmdKind <= CMD_PRE;
      else if (stb.refr) cmdKind <= CMD_REF;
      else               cmdKind <= CMD_NOP;
      cmdBank <= stb.bank;
      cmdRow  <= pendRow;
      cmdCol  <= pendCol;
      rowHit  <= stb.forReq & pendFirst & stb.col;
      rowMiss <= stb.forReq & pendFirst & (stb.act | stb.pre);
    end
  end
endmodule

// File: rtl/dramSeqCtrl.sv
module dramSeqCtrl
  import dramSeqPkg::*;
#(
  parameter int T_REFI = 7800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              pendValid,
  input  logic [BANK_W-1:0] pendBank,
  input  logic              rowMatch,
  input  logic [BANKS-1:0]  bankOpen,
  input  logic [BANKS-1:0]  rcdDone,
  input  logic [BANKS-1:0]  rasDone,
  input  logic [BANKS-1:0]  rpDone,
  output seqStrobe_t        stb
);
  localparam int REF_W = $clog2(T_REFI + 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(T_REFI - 1);

  logic [REF_W-1:0]  refCnt;
  logic              refDue;
  logic              victimFound;
  logic [BANK_W-1:0] victim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
      refDue <= 1'b0;
    end else if (stb.refr) begin
      refCnt <= '0;
      refDue <= 1'b0;
    end else if (!refDue) begin
      if (refCnt == REF_LAST) refDue <= 1'b1;
      else                    refCnt <= refCnt + 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    victimFound = 1'b0;
    victim      = '0;
    for (int i = BANKS - 1; i >= 0; i--) begin
      if (bankOpen[i]) begin
        victimFound = 1'b1;
        victim      = BANK_W'(i);
      end
    end
    if (pendValid) begin
      stb.forReq = 1'b1;
      stb.bank   = pendBank;
      if (bankOpen[pendBank]) begin
        if (rowMatch) stb.col = rcdDone[pendBank];
        else          stb.pre = rasDone[pendBank];
      end else begin
        stb.act = rpDone[pendBank];
      end
    end else if (refDue) begin
      if (victimFound) begin
        stb.bank = victim;
        stb.pre  = rasDone[victim];
      end else begin
        stb.refr = &rpDone;
      end
    end
    reqReady   = !refDue && (!pendValid || stb.col);
    stb.accept = reqValid && reqReady;
  end
endmodule

// File: rtl/dramSeq.sv
module dramSeq
  import dramSeqPkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int T_RCD  = 11,
  parameter int T_RAS  = 28,
  parameter int T_RP   = 11,
  parameter int T_RFC  = 160,
  parameter int T_REFI = 7800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [2:0]        reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic [2:0]        cmdKind,
  output logic [2:0]        cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              rowHit,
  output logic              rowMiss
);
  seqStrobe_t        stb;
  logic              pendValid;
  logic [BANK_W-1:0] pendBank;
  logic              rowMatch;
  logic [BANKS-1:0]  bankOpen, rcdDone, rasDone, rpDone;

  dramSeqCtrl #(.T_REFI(T_REFI)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .pendValid(pendValid), .pendBank(pendBank), .rowMatch(rowMatch),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .rasDone(rasDone),
    .rpDone(rpDone), .stb(stb)
  );

  dramSeqPath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .pendValid(pendValid), .pendBank(pendBank), .rowMatch(rowMatch),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .rasDone(rasDone),
    .rpDone(rpDone), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .rowHit(rowHit), .rowMiss(rowMiss)
  );
endmodule

// File: rtl/dramSeqCheck.sv
module dramSeqCheck #(
  parameter int T_RCD = 11,
  parameter int T_RAS = 28,
  parameter int T_RP  = 11,
  parameter int T_RFC = 160
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cmdKind,
  input logic [2:0] cmdBank,
  input logic       rowHit,
  input logic       rowMiss
);
  // checker-side view of the device, rebuilt from the command port only
  logic [7:0] chkOpen;
  logic [7:0] sinceAct [8];
  logic [7:0] sincePre [8];
  logic [7:0] sinceRef;
  logic       isCol;

  assign isCol = (cmdKind == 3'd2) || (cmdKind == 3'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkOpen  <= '0;
      sinceRef <= 8'hFF;
      for (int b = 0; b < 8; b++) begin
        sinceAct[b] <= 8'hFF;
        sincePre[b] <= 8'hFF;
      end
    end else begin
      sinceRef <= (cmdKind == 3'd5) ? 8'd1 : ((sinceRef == 8'hFF) ? sinceRef : sinceRef + 8'd1);
      for (int b = 0; b < 8; b++) begin
        if (cmdKind == 3'd1 && cmdBank == 3'(b)) begin
          sinceAct[b] <= 8'd1;
          chkOpen[b]  <= 1'b1;
        end else if (sinceAct[b] != 8'hFF) begin
          sinceAct[b] <= sinceAct[b] + 8'd1;
        end
        if (cmdKind == 3'd4 && cmdBank == 3'(b)) begin
          sincePre[b] <= 8'd1;
          chkOpen[b]  <= 1'b0;
        end else if (sincePre[b] != 8'hFF) begin
          sincePre[b] <= sincePre[b] + 8'd1;
        end
      end
    end
  end

  AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 3'd1) |-> !chkOpen[cmdBank]); // R1
  AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> chkOpen[cmdBank]); // R1
  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> (32'(sinceAct[cmdBank]) >= T_RCD)); // R2
  AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 3'd4) |-> (32'(sinceAct[cmdBank]) >= T_RAS)); // R3
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 3'd1) |-> (32'(sincePre[cmdBank]) >= T_RP)); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rowHit && rowMiss)); // R6
  AST_FLAG_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (rowHit || rowMiss) |-> (cmdKind != 3'd0)); // R6
  AST_HIT_IS_COL: assert property (@(posedge clk) disable iff (!rstN)
    rowHit |-> isCol); // R6
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 3'd5) |-> (chkOpen == 8'd0)); // R7
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == 3'd1) |-> (32'(sinceRef) >= T_RFC)); // R7
endmodule

bind dramSeq dramSeqCheck #(
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RFC(T_RFC)
) u_check (
  .clk(clk), .rstN(rstN), .cmdKind(cmdKind), .cmdBank(cmdBank),
  .rowHit(rowHit), .rowMiss(rowMiss)
);

// File: tb/dramSeq_bench.sv
`timescale 1ns/1ps
module dramSeq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int T_RCD  = 3;
  localparam int T_RAS  = 6;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 8;
  localparam int T_REFI = 150;
  localparam int REF_SLACK = 40;
  localparam int QMAX = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [2:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic reqReady;
  logic [2:0] cmdKind, cmdBank;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;
  logic rowHit, rowMiss;

  dramSeq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_dramSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .cmdKind(cmdKind), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .rowHit(rowHit), .rowMiss(rowMiss)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // request queue kept by the bench
  int qBank [QMAX], qRow [QMAX], qCol [QMAX], qWr [QMAX], accCyc [QMAX];
  int qHead = 0, qTail = 0;

  // bench view of the device
  bit openB [8];
  int openR [8], lastAct [8], lastPre [8];
  int lastRef = -1000, prevRef = -1, refCount = 0, pulses = 0;
  int logKind [16], logCyc [16], logN = 0;
  bit monOn = 1'b0;

  initial begin
    for (int b = 0; b < 8; b++) begin
      openB[b] = 1'b0; openR[b] = 0; lastAct[b] = -1000; lastPre[b] = -1000;
    end
  end

  always @(negedge clk) begin
    if (monOn) begin
      int b, k;
      b = int'(cmdBank);
      k = int'(cmdKind);
      if (k != 0 && logN < 16) begin
        logKind[logN] = k; logCyc[logN] = cyc; logN++;
      end
      if (rowHit || rowMiss) begin
        bit expHit;
        pulses++;
        expHit = openB[qBank[qHead]] && (openR[qBank[qHead]] == qRow[qHead]);
        check(rowHit == expHit && rowMiss == !expHit, "R6", int'(rowHit), int'(expHit), "hit flag");
        check(b == qBank[qHead], "R6", b, qBank[qHead], "flagged command bank");
      end
      case (k)
        1: begin
          check(!openB[b], "R1", int'(openB[b]), 0, "activate to open bank");
          check(cyc - lastPre[b] >= T_RP, "R4", cyc - lastPre[b], T_RP, "precharge-to-activate gap");
          check(cyc - lastRef >= T_RFC, "R7", cyc - lastRef, T_RFC, "refresh-to-activate gap");
          check(int'(cmdRow) == qRow[qHead] && b == qBank[qHead], "R8", int'(cmdRow), qRow[qHead], "activated row");
          openB[b] = 1'b1; openR[b] = int'(cmdRow); lastAct[b] = cyc;
        end
        2, 3: begin
          check(openB[b] && openR[b] == qRow[qHead], "R1", openR[b], qRow[qHead], "column on open row");
          check(cyc - lastAct[b] >= T_RCD, "R2", cyc - lastAct[b], T_RCD, "activate-to-column gap");
          check(b == qBank[qHead] && int'(cmdCol) == qCol[qHead], "R8", int'(cmdCol), qCol[qHead], "column order");
          check((k == 3) == (qWr[qHead] == 1), "R8", k, qWr[qHead] + 2, "read/write kind");
          qHead++;
        end
        4: begin
          check(openB[b], "R1", int'(openB[b]), 1, "precharge of open bank");
          check(cyc - lastAct[b] >= T_RAS, "R3", cyc - lastAct[b], T_RAS, "activate-to-precharge gap");
          openB[b] = 1'b0; lastPre[b] = cyc;
        end
        5: begin
          int nOpen;
          nOpen = 0;
          for (int i = 0; i < 8; i++) if (openB[i]) nOpen++;
          check(nOpen == 0, "R7", nOpen, 0, "open banks at refresh");
          if (prevRef >= 0) begin
            check(cyc - prevRef >= T_REFI, "R7", cyc - prevRef, T_REFI, "refresh spacing min");
            check(cyc - prevRef <= T_REFI + REF_SLACK, "R7", cyc - prevRef, T_REFI + REF_SLACK, "refresh spacing max");
          end
          prevRef = cyc; lastRef = cyc; refCount++;
        end
        default: ;
      endcase
    end
  end

  task automatic sendReq(input int bank, input int row, input int col, input int wr);
    reqValid = 1'b1; reqBank = 3'(bank); reqRow = ROW_W'(row);
    reqCol = COL_W'(col); reqWrite = wr[0];
    while (!reqReady) @(negedge clk);
    qBank[qTail] = bank; qRow[qTail] = row; qCol[qTail] = col; qWr[qTail] = wr;
    accCyc[qTail] = cyc + 1;
    qTail++;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(cmdKind == 3'd0, "R9", int'(cmdKind), 0, "command in reset");
    check(!rowHit && !rowMiss, "R9", int'(rowHit | rowMiss), 0, "flags in reset");
    @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    check(cmdKind == 3'd0, "R9", int'(cmdKind), 0, "command after reset");
    check(reqReady == 1'b1, "R9", int'(reqReady), 1, "ready after reset");

    // R5: exact timing of a miss, a back-to-back hit and a conflict
    sendReq(2, 5, 1, 0);
    sendReq(2, 5, 2, 1);
    sendReq(2, 9, 3, 0);
    repeat (30) @(negedge clk);
    check(logN >= 6, "R5", logN, 6, "commands in directed trace");
    check(logKind[0] == 1 && logCyc[0] == accCyc[0] + 1, "R5", logCyc[0], accCyc[0] + 1, "activate cycle");
    check(logKind[1] == 2 && logCyc[1] == logCyc[0] + T_RCD, "R5", logCyc[1], logCyc[0] + T_RCD, "read cycle");
    check(logKind[2] == 3 && logCyc[2] == logCyc[1] + 1, "R5", logCyc[2], logCyc[1] + 1, "back-to-back write cycle");
    e = (accCyc[2] + 1 > logCyc[0] + T_RAS) ? accCyc[2] + 1 : logCyc[0] + T_RAS;
    check(logKind[3] == 4 && logCyc[3] == e, "R5", logCyc[3], e, "conflict precharge cycle");
    check(logKind[4] == 1 && logCyc[4] == logCyc[3] + T_RP, "R5", logCyc[4], logCyc[3] + T_RP, "reactivate cycle");
    check(logKind[5] == 2 && logCyc[5] == logCyc[4] + T_RCD, "R5", logCyc[5], logCyc[4] + T_RCD, "conflict read cycle");

    // sweep: every bank, every ordered pair of rows
    for (int b = 0; b < 8; b++)
      for (int r1 = 0; r1 < 4; r1++)
        for (int r2 = 0; r2 < 4; r2++) begin
          sendReq(b, r1, (r1 + b) % 8, r2 % 2);
          sendReq(b, r2, (r2 + 3) % 8, r1 % 2);
        end
    // interleaved banks with recurring rows
    for (int i = 0; i < 160; i++)
      sendReq((i * 3) % 8, (i / 8) % 3, i % 8, (i / 5) % 2);

    e = 0;
    while (qHead != qTail && e < 2000) begin @(negedge clk); e++; end
    repeat (T_REFI + REF_SLACK) @(negedge clk);
    check(qHead == qTail, "R8", qHead, qTail, "all requests completed");
    check(pulses == qTail, "R6", pulses, qTail, "one flag pulse per request");
    check(refCount >= 2, "R7", refCount, 2, "refreshes issued");
    finishRun();
  end
endmodule